// File: doc/BRIEF.md
# Length-Prefixed Command Stream Splitter

The block sits behind a host endpoint whose transfers may carry several commands packed back to back. It takes a byte stream with a transfer length supplied on the first byte of each transfer, finds message boundaries from a length field inside each message header, and forwards every complete message with start and end markers. Transport framing plays no part in finding the boundaries. Each message opens with a four-byte header: byte 0 is the class, byte 1 is the type, and bytes 2 and 3 hold the total message length, header included, low byte first. The payload follows directly after byte 3.

A header is held back until its length bytes have arrived. That way an inconsistent message is never partly forwarded. A message whose declared length runs past the end of the transfer, or is shorter than a header, raises a one-cycle error pulse. The remaining bytes of that transfer are then swallowed. Both sides use valid/ready handshakes. Payload bytes pass straight through, so the output's ready signal throttles the input.

Top module: `cmd_splitter`

## Requirements
- R1: When the first header declares exactly the transfer length, the whole transfer is forwarded as one message, with out_sop on its first byte and out_eop on its last.
- R2: Otherwise messages are forwarded one after another, each exactly as long as its header declares, with bytes in arrival order, until the transfer is used up.
- R3: If a declared length (bytes 2 and 3 of the header, low byte first) exceeds the bytes left in the transfer from that header's first byte, none of that message is forwarded, the rest of the transfer is discarded, and err_o pulses high for one cycle.
- R4: A declared length below 4, zero included, is an error: the message is not forwarded, the rest of the transfer is discarded, and err_o pulses once.
- R5: If fewer than 4 bytes of a transfer remain where a header should start, including a transfer of 1 to 3 bytes, those bytes are discarded and err_o pulses once.
- R6: out_hdr is high on exactly the first 4 output bytes of each message and low on payload bytes. A message declaring length 4 carries out_sop on its first byte and out_eop on its fourth.
- R7: A byte accepted while no transfer is open and in_first is low produces no output and no error.
- R8: While out_ready is low, no byte is lost or duplicated. Buffered header bytes are held stable on out_data until accepted.
- R9: After reset, out_valid and err_o are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_data | input | DATA_W | Input byte |
| in_first | input | 1 | Marks the first byte of a transfer |
| in_xfer_len | input | 2*DATA_W | Transfer length in bytes, sampled with the first byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Output byte |
| out_sop | output | 1 | First byte of a message |
| out_eop | output | 1 | Last byte of a message |
| out_hdr | output | 1 | Byte belongs to the message header |
| err_o | output | 1 | One-cycle pulse on a length inconsistency |

## Verification
The hardest cases to reach are the boundary decisions made mid-transfer. One is a later message whose length overruns the transfer after earlier messages were already forwarded. Another is a transfer tail shorter than a header. A third is a header-only message whose end marker falls on a buffered byte while the output is stalled. Directed transfers build each of these byte by byte. Seeded random transfers then pack one to four messages with random payload sizes, corrupt a declared length now and then, and vary input gaps and output ready, so that each boundary decision is also met under backpressure.

// File: rtl/csplit_pkg.sv
package csplit_pkg;
    localparam int HDR_BYTES  = 4;
    localparam int LEN_LO_POS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_EMIT,
        ST_PAY,
        ST_DROP
    } st_e;
endpackage

// File: rtl/csplit_hdr_buf.sv
module csplit_hdr_buf #(
    parameter int DATA_W = 8,
    parameter int NBYTES = 4,
    parameter int LO_POS = 2,
    localparam int IDX_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] len_lo
);
    logic [DATA_W-1:0] byte_q [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                byte_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = byte_q[rd_idx];
    assign len_lo  = byte_q[LO_POS];
endmodule

// File: rtl/csplit_len_check.sv
module csplit_len_check #(
    parameter int LEN_W  = 16,
    parameter int NBYTES = 4
) (
    input  logic [LEN_W-1:0] decl_len,
    input  logic [LEN_W-1:0] rem_after,
    output logic             too_short,
    output logic             too_long,
    output logic [LEN_W-1:0] pay_len
);
    always_comb begin
        too_short = decl_len < LEN_W'(NBYTES);
        pay_len   = decl_len - LEN_W'(NBYTES);
        too_long  = !too_short && (pay_len > rem_after);
    end
endmodule

// File: rtl/csplit_boundary.sv
module csplit_boundary #(
    parameter int LEN_W  = 16,
    parameter int NBYTES = 4
) (
    input  logic [LEN_W-1:0] b_rem,
    output logic             go_idle,
    output logic             go_short
);
    always_comb begin
        go_idle  = (b_rem == '0);
        go_short = (b_rem != '0) && (b_rem < LEN_W'(NBYTES));
    end
endmodule

// File: rtl/cmd_splitter.sv
module cmd_splitter
    import csplit_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int LEN_W = 2 * DATA_W,
    localparam int IDX_W = $clog2(HDR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_first,
    input  logic [LEN_W-1:0]  in_xfer_len,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_hdr,
    output logic              err_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BYTES - 1);

    typedef struct packed {
        st_e              st;
        logic [IDX_W-1:0] idx;
        logic [LEN_W-1:0] rem;
        logic [LEN_W-1:0] mrem;
        logic             err;
    } state_t;

    state_t s_d, s_q;

    logic              hb_we;
    logic [IDX_W-1:0]  hb_widx;
    logic [DATA_W-1:0] hb_rd;
    logic [DATA_W-1:0] hb_lo;
    logic              lc_short, lc_long;
    logic [LEN_W-1:0]  lc_pay;
    logic [LEN_W-1:0]  b_rem;
    logic              bd_idle, bd_short;
    logic              take_bnd;

    csplit_hdr_buf #(
        .DATA_W (DATA_W),
        .NBYTES (HDR_BYTES),
        .LO_POS (LEN_LO_POS)
    ) u_hdr_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hb_we),
        .wr_idx  (hb_widx),
        .wr_data (in_data),
        .rd_idx  (s_q.idx),
        .rd_data (hb_rd),
        .len_lo  (hb_lo)
    );

    csplit_len_check #(
        .LEN_W  (LEN_W),
        .NBYTES (HDR_BYTES)
    ) u_len_check (
        .decl_len  ({in_data, hb_lo}),
        .rem_after (s_q.rem - LEN_W'(1)),
        .too_short (lc_short),
        .too_long  (lc_long),
        .pay_len   (lc_pay)
    );

    csplit_boundary #(
        .LEN_W  (LEN_W),
        .NBYTES (HDR_BYTES)
    ) u_boundary (
        .b_rem    (b_rem),
        .go_idle  (bd_idle),
        .go_short (bd_short)
    );

    always_comb begin
        s_d       = s_q;
        s_d.err   = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = hb_rd;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        out_hdr   = 1'b0;
        hb_we     = 1'b0;
        hb_widx   = s_q.idx;
        b_rem     = s_q.rem;
        take_bnd  = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid && in_first) begin
                    hb_we   = 1'b1;
                    hb_widx = '0;
                    s_d.rem = in_xfer_len - LEN_W'(1);
                    s_d.idx = IDX_W'(1);
                    if (in_xfer_len < LEN_W'(HDR_BYTES)) begin
                        s_d.err = 1'b1;
                        s_d.st  = (in_xfer_len <= LEN_W'(1)) ? ST_IDLE : ST_DROP;
                    end else begin
                        s_d.st = ST_HDR;
                    end
                end
            end
            ST_HDR: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    hb_we   = 1'b1;
                    s_d.rem = s_q.rem - LEN_W'(1);
                    if (s_q.idx == LAST_IDX) begin
                        if (lc_short || lc_long) begin
                            s_d.err = 1'b1;
                            s_d.st  = (s_q.rem == LEN_W'(1)) ? ST_IDLE : ST_DROP;
                        end else begin
                            s_d.st   = ST_EMIT;
                            s_d.idx  = '0;
                            s_d.mrem = lc_pay;
                        end
                    end else begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                    end
                end
            end
            ST_EMIT: begin
                out_valid = 1'b1;
                out_hdr   = 1'b1;
                out_sop   = (s_q.idx == '0);
                out_eop   = (s_q.idx == LAST_IDX) && (s_q.mrem == '0);
                if (out_ready) begin
                    if (s_q.idx == LAST_IDX) begin
                        s_d.idx = '0;
                        if (s_q.mrem == '0) begin
                            take_bnd = 1'b1;
                        end else begin
                            s_d.st = ST_PAY;
                        end
                    end else begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                    end
                end
            end
            ST_PAY: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                out_data  = in_data;
                out_eop   = (s_q.mrem == LEN_W'(1));
                if (in_valid && out_ready) begin
                    s_d.rem  = s_q.rem - LEN_W'(1);
                    s_d.mrem = s_q.mrem - LEN_W'(1);
                    if (s_q.mrem == LEN_W'(1)) begin
                        take_bnd = 1'b1;
                        b_rem    = s_q.rem - LEN_W'(1);
                    end
                end
            end
            ST_DROP: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    s_d.rem = s_q.rem - LEN_W'(1);
                    if (s_q.rem == LEN_W'(1)) begin
                        s_d.st = ST_IDLE;
                    end
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase

        if (take_bnd) begin
            s_d.rem = b_rem;
            if (bd_idle) begin
                s_d.st = ST_IDLE;
            end else if (bd_short) begin
                s_d.err = 1'b1;
                s_d.st  = ST_DROP;
            end else begin
                s_d.st  = ST_HDR;
                s_d.idx = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, idx: '0, rem: '0, mrem: '0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign err_o = s_q.err;

    // R2: after a message end is taken, the next cycle carries no output byte
    a_r2_eop_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> !out_valid);

    // R6: a message start always lies inside the header
    a_r6_sop_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> out_hdr);

    // R3: an error pulse never coincides with forwarded data
    a_r3_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !out_valid);

    // R8: a stalled header byte stays put
    a_r8_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hdr && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7: the input is taken without stall while no transfer is open
    a_r7_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE) |-> in_ready);
endmodule

// File: tb/test_cmd_splitter.sv
`timescale 1ns/1ps
module test_cmd_splitter;
    typedef logic [10:0] rec_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_data;
    logic        in_first;
    logic [15:0] in_xfer_len;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_data;
    logic        out_sop, out_eop, out_hdr;
    logic        err_o;

    int   n_cmp = 0;
    int   n_bad = 0;
    rec_t got_q[$];
    rec_t exp_q[$];
    int   got_err = 0;
    int   exp_err = 0;
    bit   ready_mode = 1'b0;
    bit   run_on = 1'b0;

    always #2.5 clk = ~clk;

    cmd_splitter i_cmd_splitter (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .in_first    (in_first),
        .in_xfer_len (in_xfer_len),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_sop     (out_sop),
        .out_eop     (out_eop),
        .out_hdr     (out_hdr),
        .err_o       (err_o)
    );

    initial begin
        out_ready = 1'b0;
        forever begin
            @(negedge clk);
            out_ready = run_on && (ready_mode || ($urandom % 4 != 0));
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n === 1'b1) begin
                if (out_valid && out_ready) got_q.push_back({out_hdr, out_sop, out_eop, out_data});
                if (err_o) got_err++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic void model(input byte unsigned b[$]);
        int p, len, total;
        total = b.size();
        p = 0;
        exp_q.delete();
        exp_err = 0;
        while (p < total) begin
            if (total - p < 4) begin exp_err = 1; break; end
            len = int'(b[p+2]) | (int'(b[p+3]) << 8);
            if (len < 4 || len > total - p) begin exp_err = 1; break; end
            for (int k = 0; k < len; k++)
                exp_q.push_back({(k < 4), (k == 0), (k == len - 1), b[p+k]});
            p += len;
        end
    endfunction

    task automatic add_msg(ref byte unsigned q[$], input int decl, input int npay);
        q.push_back(8'($urandom));
        q.push_back(8'($urandom));
        q.push_back(8'(decl));
        q.push_back(8'(decl >> 8));
        for (int k = 0; k < npay; k++) q.push_back(8'($urandom));
    endtask

    task automatic send_xfer(input byte unsigned b[$]);
        for (int i = 0; i < b.size(); i++) begin
            if ($urandom % 4 == 0) begin @(negedge clk); in_valid = 1'b0; end
            @(negedge clk);
            in_valid    = 1'b1;
            in_data     = b[i];
            in_first    = (i == 0);
            in_xfer_len = 16'(b.size());
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
    endtask

    task automatic verify(input string tag, input string etag);
        int n;
        repeat (40) @(negedge clk);
        chk(got_q.size() == exp_q.size(), tag, "output byte count", got_q.size(), exp_q.size());
        n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
        for (int i = 0; i < n; i++) begin
            chk(got_q[i][7:0] == exp_q[i][7:0], tag, "data byte", int'(got_q[i][7:0]), int'(exp_q[i][7:0]));
            chk(got_q[i][10:8] == exp_q[i][10:8], "R6", "hdr/sop/eop markers", int'(got_q[i][10:8]), int'(exp_q[i][10:8]));
        end
        chk(got_err == exp_err, etag, "error pulses", got_err, exp_err);
    endtask

    task automatic run_xfer(input byte unsigned b[$], input string tag, input string etag);
        model(b);
        got_q.delete();
        got_err = 0;
        send_xfer(b);
        verify(tag, etag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        byte unsigned q[$];
        void'($urandom(32'd1357));
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_first = 1'b0; in_xfer_len = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);
        chk(err_o == 1'b0, "R9", "err_o after reset", int'(err_o), 0);
        run_on = 1'b1;

        // R1: one message fills the transfer exactly
        q.delete(); add_msg(q, 10, 6); run_xfer(q, "R1", "R1");
        // R2: three packed messages, one header-only
        q.delete(); add_msg(q, 9, 5); add_msg(q, 4, 0); add_msg(q, 7, 3); run_xfer(q, "R2", "R2");
        // R6: header-only message alone
        q.delete(); add_msg(q, 4, 0); run_xfer(q, "R6", "R6");
        // R3: second message overruns the transfer
        q.delete(); add_msg(q, 6, 2); add_msg(q, 20, 4); run_xfer(q, "R3", "R3");
        // R3: first message overruns by one byte
        q.delete(); add_msg(q, 9, 4); run_xfer(q, "R3", "R3");
        // R4: declared length below header size, then zero
        q.delete(); add_msg(q, 2, 5); run_xfer(q, "R4", "R4");
        q.delete(); add_msg(q, 5, 1); add_msg(q, 0, 3); run_xfer(q, "R4", "R4");
        // R5: tail shorter than a header, and a very short transfer
        q.delete(); add_msg(q, 6, 2); q.push_back(8'h11); q.push_back(8'h22); run_xfer(q, "R5", "R5");
        q.delete(); q.push_back(8'hA1); q.push_back(8'hA2); q.push_back(8'hA3); run_xfer(q, "R5", "R5");
        q.delete(); q.push_back(8'hB1); run_xfer(q, "R5", "R5");

        // R7: stray byte without in_first while idle
        q.delete(); add_msg(q, 6, 2);
        model(q); got_q.delete(); got_err = 0;
        @(negedge clk); in_valid = 1'b1; in_first = 1'b0; in_data = 8'h06; in_xfer_len = 16'd6;
        #1; while (!in_ready) begin @(negedge clk); #1; end
        @(negedge clk); in_valid = 1'b0;
        send_xfer(q);
        verify("R7", "R7");

        // R8: full-rate output, then seeded random traffic with backpressure
        ready_mode = 1'b1;
        q.delete(); add_msg(q, 8, 4); add_msg(q, 5, 1); run_xfer(q, "R8", "R8");
        ready_mode = 1'b0;
        for (int t = 0; t < 60; t++) begin
            int nm;
            q.delete();
            nm = 1 + int'($urandom % 4);
            for (int m = 0; m < nm; m++) begin
                int np, dl;
                np = int'($urandom % 9);
                dl = np + 4;
                if ($urandom % 8 == 0) dl = int'($urandom % 40);
                add_msg(q, dl, np);
            end
            run_xfer(q, "R8", "R3");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule